// File: doc/BRIEF.md
# DMA Channel Interrupt Status Unit

This block keeps the completion and error state for every channel of a multi-channel DMA controller and turns it into a single interrupt line. Each channel's command engine can pulse three event inputs: command done, termination, and bus error. The block latches these into two status registers. Software reaches the registers over a simple word-wide register bus.

Each status register has three addresses. The base address replaces the whole register. The set alias ORs the written ones in, and the clear alias removes only the bits written as one. The block sorts the pending events. A termination counts as a real error when it carries the bus-error qualifier, or when the same channel has no completion flag. A termination that meets a completion on the same channel is benign. A read-only register names the next event to service: the highest pending bit, with errors ranking above completions. Every new error also raises a one-cycle reset request for its channel.

Top module: `dma_irq_status`

## Requirements
- R1: After reset both status registers read 0 (all flags, qualifiers and enables cleared), `irq` is 0, `chan_rst_req` is 0 and the next-event register reads 0x3F.
- R2: Status register A is at 0x00. Bits [15:0] are the completion flags and bits [31:16] are the interrupt enables. Status register B is at 0x10. Bits [15:0] are the termination flags and bits [31:16] are the bus-error qualifiers. A `done_evt[i]` pulse sets A[i]. A `term_evt[i]` pulse sets B[i]. A `buserr_evt[i]` pulse sets both B[i] and B[16+i]. Each flag is visible in the cycle after the pulse and stays set until software clears it.
- R3: A write to base+0x4 sets exactly the bits written as 1. A write to base+0x8 clears exactly the bits written as 1. A write to the base address replaces the register.
- R4: When an event and a clear-alias write hit the same flag in the same cycle, the flag ends up set.
- R5: Channel i is in error when B[i] and B[16+i] are both set, or when B[i] is set while B[16+i] and A[i] are both clear. When B[i] and A[i] are set and B[16+i] is clear, the channel counts only as a completion.
- R6: The next-event register at 0x20 returns the position of the highest set bit of {error vector, completion flags}. Values 0..15 mean a completion on that channel. Values 16..31 mean an error on channel value-16. The register reads 0x3F when nothing is pending.
- R7: `irq` is high exactly when some completion flag has its enable set, or when some channel is in error.
- R8: `chan_rst_req[i]` is high for exactly one cycle, in the cycle after channel i first enters the error state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte address for both reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| done_evt | input | 16 | Per-channel command-complete pulses |
| term_evt | input | 16 | Per-channel termination pulses |
| buserr_evt | input | 16 | Per-channel bus-error pulses |
| irq | output | 1 | Combined interrupt |
| chan_rst_req | output | 16 | Per-channel one-cycle reset request |

## Verification
The bench targets the benign case, where a termination coincides with a completion. A design that ignored the completion would flag an error there, raise `irq` and issue a reset request. The same termination is then given a bus-error qualifier, which must turn it into an error. A design that exempted every termination carrying a completion would miss that error. The bench also drives a clear and an event onto the same flag in one cycle, where a design that let the clear win would lose the event. Finally it checks the next-event ordering with both halves populated, so an encoder that picked the lowest bit, or ranked completions first, would return the wrong index.

// File: rtl/dma_irq_status.sv
module dma_irq_status #(
  parameter int NCH = 16,
  parameter int AW  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [AW-1:0]     reg_addr,
  input  logic [2*NCH-1:0]  reg_wdata,
  output logic [2*NCH-1:0]  reg_rdata,
  input  logic [NCH-1:0]    done_evt,
  input  logic [NCH-1:0]    term_evt,
  input  logic [NCH-1:0]    buserr_evt,
  output logic              irq,
  output logic [NCH-1:0]    chan_rst_req
);
  localparam int RW = 2 * NCH;
  localparam int IW = $clog2(RW) + 1;
  localparam logic [IW-1:0] NONE = '1;
  localparam logic [AW-1:0] A_BASE = AW'(8'h00);
  localparam logic [AW-1:0] A_SET  = AW'(8'h04);
  localparam logic [AW-1:0] A_CLR  = AW'(8'h08);
  localparam logic [AW-1:0] B_BASE = AW'(8'h10);
  localparam logic [AW-1:0] B_SET  = AW'(8'h14);
  localparam logic [AW-1:0] B_CLR  = AW'(8'h18);
  localparam logic [AW-1:0] NXT    = AW'(8'h20);

  logic [RW-1:0]  stat_a, stat_b, nxt_a, nxt_b;
  logic [NCH-1:0] err_vec, err_prev;
  logic [RW-1:0]  pend;
  logic [IW-1:0]  pick;

  wire [NCH-1:0] done_f = stat_a[NCH-1:0];
  wire [NCH-1:0] en     = stat_a[RW-1:NCH];
  wire [NCH-1:0] term_f = stat_b[NCH-1:0];
  wire [NCH-1:0] qual   = stat_b[RW-1:NCH];

  assign err_vec = (term_f & qual) | (term_f & ~qual & ~done_f);
  assign pend    = {err_vec, done_f};
  assign irq     = (|(done_f & en)) | (|err_vec);

  always_comb begin
    nxt_a = stat_a;
    nxt_b = stat_b;
    if (reg_wr) begin
      case (reg_addr)
        A_BASE:  nxt_a = reg_wdata;
        A_SET:   nxt_a = stat_a | reg_wdata;
        A_CLR:   nxt_a = stat_a & ~reg_wdata;
        B_BASE:  nxt_b = reg_wdata;
        B_SET:   nxt_b = stat_b | reg_wdata;
        B_CLR:   nxt_b = stat_b & ~reg_wdata;
        default: ;
      endcase
    end
    nxt_a[NCH-1:0]  = nxt_a[NCH-1:0] | done_evt;
    nxt_b[NCH-1:0]  = nxt_b[NCH-1:0] | term_evt | buserr_evt;
    nxt_b[RW-1:NCH] = nxt_b[RW-1:NCH] | buserr_evt;
  end

  always_comb begin
    pick = NONE;
    for (int i = 0; i < RW; i++)
      if (pend[i]) pick = IW'(i);
  end

  always_comb begin
    case (reg_addr)
      A_BASE, A_SET, A_CLR: reg_rdata = stat_a;
      B_BASE, B_SET, B_CLR: reg_rdata = stat_b;
      NXT:                  reg_rdata = RW'(pick);
      default:              reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_a       <= '0;
      stat_b       <= '0;
      err_prev     <= '0;
      chan_rst_req <= '0;
    end else begin
      stat_a       <= nxt_a;
      stat_b       <= nxt_b;
      err_prev     <= err_vec;
      chan_rst_req <= err_vec & ~err_prev;
    end
  end

  p_done_latched_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (done_evt != '0) |=> ((done_f & $past(done_evt)) == $past(done_evt)));

  p_clear_keeps_zeros_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_CLR) |=>
      ((($past(stat_a) & ~$past(reg_wdata)) & ~stat_a) == '0));

  p_event_beats_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_CLR && (done_evt & reg_wdata[NCH-1:0]) != '0) |=>
      ((done_f & $past(done_evt)) == $past(done_evt)));

  p_idle_next_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == NXT && done_f == '0 && term_f == '0) |-> (reg_rdata == RW'(NONE)));

  p_quiet_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_f == '0 && term_f == '0) |-> !irq);

  p_single_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_rst_req != '0) |=> ((chan_rst_req & $past(chan_rst_req)) == '0));
endmodule

// File: tb/dma_irq_status_bench.sv
module dma_irq_status_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        reg_wr = 0;
  logic [7:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic [15:0] done_evt = 0, term_evt = 0, buserr_evt = 0;
  logic        irq;
  logic [15:0] chan_rst_req;

  int checks = 0, errors = 0;
  bit finished = 0;
  bit mon_go = 0;

  typedef struct { int kind; logic [31:0] exp; string tag; } item_t;
  item_t q[$];

  always #5 clk = ~clk;

  dma_irq_status u_dma_irq_status (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .done_evt(done_evt),
    .term_evt(term_evt), .buserr_evt(buserr_evt), .irq(irq),
    .chan_rst_req(chan_rst_req));

  always @(negedge clk) begin
    if (mon_go && q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      case (it.kind)
        0: act = reg_rdata;
        1: act = {31'd0, irq};
        default: act = {16'd0, chan_rst_req};
      endcase
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  task automatic expect_val(input int kind, input logic [7:0] a, input logic [31:0] e, input string tag);
    item_t it;
    it.kind = kind; it.exp = e; it.tag = tag;
    reg_addr = a;
    q.push_back(it);
    mon_go = 1;
    @(posedge clk); #1;
    mon_go = 0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 0;
  endtask

  task automatic pulse(input logic [15:0] d, input logic [15:0] t, input logic [15:0] b);
    done_evt = d; term_evt = t; buserr_evt = b;
    @(posedge clk); #1;
    done_evt = 0; term_evt = 0; buserr_evt = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    expect_val(0, 8'h00, 32'h0, "R1 stat A");
    expect_val(0, 8'h10, 32'h0, "R1 stat B");
    expect_val(0, 8'h20, 32'h3F, "R1 next idle");
    expect_val(1, 8'h00, 32'h0, "R1 irq");
    expect_val(2, 8'h00, 32'h0, "R1 rst req");
    // R2 completion latch, no enable
    pulse(16'h0005, 0, 0);
    expect_val(0, 8'h00, 32'h5, "R2 done flags");
    expect_val(0, 8'h20, 32'd2, "R6 highest completion");
    expect_val(1, 8'h00, 32'h0, "R7 irq masked");
    // R3 set and clear aliases
    wr(8'h04, 32'h0004_0000);
    expect_val(0, 8'h00, 32'h0004_0005, "R3 set alias");
    expect_val(1, 8'h00, 32'h1, "R7 irq enabled");
    wr(8'h08, 32'h0000_0004);
    expect_val(0, 8'h00, 32'h0004_0001, "R3 clear alias");
    expect_val(1, 8'h00, 32'h0, "R7 irq after clear");
    // R5/R8 termination without completion is an error
    pulse(0, 16'h0008, 0);
    expect_val(2, 8'h00, 32'h0, "R8 rst not yet");
    expect_val(2, 8'h00, 32'h8, "R8 rst pulse");
    expect_val(2, 8'h00, 32'h0, "R8 rst single");
    expect_val(0, 8'h10, 32'h8, "R2 term flag");
    expect_val(0, 8'h20, 32'd19, "R6 error rank");
    expect_val(1, 8'h00, 32'h1, "R7 irq on error");
    wr(8'h18, 32'h8);
    // R5 benign termination with completion
    pulse(16'h0020, 16'h0020, 0);
    expect_val(2, 8'h00, 32'h0, "R5 no rst benign");
    expect_val(0, 8'h20, 32'd5, "R5 benign is completion");
    expect_val(1, 8'h00, 32'h0, "R5 no irq benign");
    // R5 bus error qualifier makes it an error
    pulse(0, 0, 16'h0020);
    expect_val(0, 8'h10, 32'h0020_0020, "R2 bus error bits");
    expect_val(0, 8'h20, 32'd21, "R5 bus error wins");
    expect_val(1, 8'h00, 32'h1, "R7 irq bus error");
    // R4 event beats same-cycle clear
    done_evt = 16'h0001;
    wr(8'h08, 32'h0000_0001);
    done_evt = 0;
    expect_val(0, 8'h00, 32'h0004_0021, "R4 event wins");
    // R3 base write replaces
    wr(8'h00, 32'h8000_0000);
    wr(8'h10, 32'h0);
    expect_val(0, 8'h00, 32'h8000_0000, "R3 base write");
    expect_val(0, 8'h20, 32'h3F, "R6 empty again");
    expect_val(1, 8'h00, 32'h0, "R7 irq idle");
    // R6 ordering
    pulse(16'h8001, 0, 0);
    expect_val(0, 8'h20, 32'd15, "R6 top completion");
    expect_val(1, 8'h00, 32'h1, "R7 enabled ch15");
    pulse(0, 16'h0001, 0);
    expect_val(0, 8'h20, 32'd15, "R5 ch0 benign keeps order");
    pulse(0, 16'h0002, 0);
    expect_val(0, 8'h20, 32'd17, "R6 error above completion");
    while (q.size() > 0) @(posedge clk);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule